// File: doc/BRIEF.md
# I2C Client Address Matcher

This block judges the address phase of each I2C transfer and decides whether the local client is being selected. A bus front end passes it whole received bytes with a valid strobe, along with one-cycle start and stop indications. The block does not sample SCL or SDA, drive ACK or handle the data phase. A 32-bit configuration word holds the following:

- the primary client address;
- a secondary 10-bit field;
- a 10-bit addressing enable;
- a general-call enable.

A separate 2-bit mode input selects how the secondary field is used. It can be a don't-care mask, a second address, or the lower bound of an accepted address range.

When a match is accepted, the block sets a sticky match flag, which stays set until the clear input is pulsed. It also records the transfer direction and whether the match was a general call. Ten-bit addresses are handled as a two-byte write sequence. A short read form is also accepted: after a repeated start, the same header byte with the read bit set matches on its own.

Top module: `i2c_client_addr_match`

## Requirements
- R1: After reset the configuration word is zero and `match_flag`, `dir_rd` and `gcall_seen` are 0. A write of `cfg_wdata` with `cfg_we` high takes the primary address from bits 10:1, the 10-bit enable from bit 15, the general-call enable from bit 0 and the secondary field from bits 26:17.
- R2: With the 10-bit enable clear, the first byte after a start is taken as {address[6:0], rw}, where rw is bit 0 and 1 means read. Only address bits 6:0 are compared.
- R3: With the 10-bit enable set, a first byte of the form 11110, a[9:8], 0 followed by a second byte a[7:0] is compared on all ten bits. No match can be raised before the second byte. A header with rw = 1 never starts this two-byte sequence.
- R4: After a 10-bit write match, a start followed by a header 11110, a[9:8], 1 whose a[9:8] equal those of the matched address is a match on its own, with direction read.
- R5: Mode 0 (mask) and mode 3 (reserved, treated as mask): an address bit whose secondary-field bit is 1 is a don't-care.
- R6: Mode 1 (second address): the received address matches if it equals either the primary address or the secondary field.
- R7: Mode 2 (range): the received address matches when secondary <= address <= primary, with both bounds inclusive.
- R8: A first byte of 0x00 is a general call. It matches, with `gcall_seen` = 1 and `dir_rd` = 0, only when the general-call enable is set; otherwise it never matches.
- R9: `match_flag` is set by any accepted match one cycle after the byte and stays set until `flag_clr` is pulsed. A match in the same cycle as `flag_clr` leaves the flag set.
- R10: `dir_rd` and `gcall_seen` change only when a match is accepted. On a match, `dir_rd` takes the rw bit and `gcall_seen` shows whether it was a general call.
- R11: A stop, or a first byte after a start that is not accepted, cancels the 10-bit read permission from R4. Bytes that arrive without a preceding start in the same address phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |
| mode_sel | input | 2 | Secondary-field mode: 0 mask, 1 second address, 2 range, 3 mask |
| start_in | input | 1 | Start or repeated start seen (one cycle) |
| stop_in | input | 1 | Stop seen (one cycle) |
| byte_vld | input | 1 | Received byte valid (one cycle) |
| byte_data | input | 8 | Received byte, MSB first as on the bus |
| flag_clr | input | 1 | Clears the sticky match flag |
| match_flag | output | 1 | Sticky address match flag |
| dir_rd | output | 1 | Direction of the last match, 1 = read |
| gcall_seen | output | 1 | Last match was a general call |

## Verification
The assertions assume that `start_in`, `stop_in` and `byte_vld` are single-cycle pulses that never share a cycle. They also assume that configuration and mode stay steady during an address phase. The bench drives every event as one strobe framed by idle cycles, and it changes configuration only between transfers. Random transfers draw the mode and the 7-bit configuration from a fixed-seed generator and bias the byte toward the primary and secondary values. Directed sequences cover the 10-bit paths, the range edges and the general call.

// File: rtl/i2c_client_addr_match_pkg.sv
package i2c_client_addr_match_pkg;
  localparam int ADDR_W  = 10;
  localparam int SHORT_W = 7;
  localparam int BYTE_W  = 8;
  localparam int CFG_W   = 32;
  localparam int HI_W    = ADDR_W - BYTE_W;

  // bit positions inside the configuration word
  localparam int POS_GCEN = 0;
  localparam int POS_PRIM = 1;
  localparam int POS_TEN  = 15;
  localparam int POS_SEC  = 17;

  // first byte of a 10-bit header: 11110 xx rw
  localparam logic [4:0] TEN_HDR = 5'b11110;

  typedef enum logic [1:0] {
    MODE_MASK  = 2'd0,
    MODE_DUAL  = 2'd1,
    MODE_RANGE = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_LOW  = 2'd2
  } seq_e;

  typedef struct packed {
    logic [ADDR_W-1:0] sec;
    logic              ten;
    logic [ADDR_W-1:0] prim;
    logic              gcen;
  } cfg_t;
endpackage

// File: rtl/i2c_client_addr_cfg.sv
module i2c_client_addr_cfg
  import i2c_client_addr_match_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output cfg_t             cfg
);
  cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.gcen = cfg_wdata[POS_GCEN];
      cfg_d.prim = cfg_wdata[POS_PRIM +: ADDR_W];
      cfg_d.ten  = cfg_wdata[POS_TEN];
      cfg_d.sec  = cfg_wdata[POS_SEC +: ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/i2c_client_addr_cmp.sv
module i2c_client_addr_cmp
  import i2c_client_addr_match_pkg::*;
(
  input  cfg_t              cfg,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic              cmp_ok
);
  logic [ADDR_W-1:0] wmask;
  logic [ADDR_W-1:0] rx_m, prim_m, sec_m;
  logic              ok_mask, ok_dual, ok_range;

  // bits above the short width only count in 10-bit mode
  for (genvar i = 0; i < ADDR_W; i++) begin : g_wmask
    if (i < SHORT_W) begin : g_lo
      assign wmask[i] = 1'b1;
    end else begin : g_hi
      assign wmask[i] = cfg.ten;
    end
  end

  assign rx_m   = rx_addr  & wmask;
  assign prim_m = cfg.prim & wmask;
  assign sec_m  = cfg.sec  & wmask;

  assign ok_mask  = ((rx_m ^ prim_m) & ~sec_m) == '0;
  assign ok_dual  = (rx_m == prim_m) || (rx_m == sec_m);
  assign ok_range = (rx_m >= sec_m) && (rx_m <= prim_m);

  always_comb begin
    unique case (mode_e'(mode_sel))
      MODE_DUAL:  cmp_ok = ok_dual;
      MODE_RANGE: cmp_ok = ok_range;
      default:    cmp_ok = ok_mask;
    endcase
  end
endmodule

// File: rtl/i2c_client_addr_seq.sv
module i2c_client_addr_seq
  import i2c_client_addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              start_in,
  input  logic              stop_in,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              cmp_ok,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic              hit,
  output logic              hit_rd,
  output logic              hit_gc
);
  seq_e            st_d, st_q;
  logic            armed_d, armed_q;
  logic [HI_W-1:0] hi_d, hi_q;
  logic [HI_W-1:0] hdr_d, hdr_q;
  logic            is_zero, is_hdr;

  assign is_zero = (byte_data == '0);
  assign is_hdr  = (byte_data[BYTE_W-1 -: 5] == TEN_HDR);

  always_comb begin
    if (st_q == SEQ_LOW) cmp_addr = {hdr_q, byte_data};
    else                 cmp_addr = {{(ADDR_W-BYTE_W+1){1'b0}}, byte_data[BYTE_W-1:1]};
  end

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    hi_d    = hi_q;
    hdr_d   = hdr_q;
    hit     = 1'b0;
    hit_rd  = 1'b0;
    hit_gc  = 1'b0;
    if (stop_in) begin
      st_d    = SEQ_IDLE;
      armed_d = 1'b0;
    end else if (start_in) begin
      st_d = SEQ_ADDR;
    end else if (byte_vld) begin
      unique case (st_q)
        SEQ_ADDR: begin
          st_d    = SEQ_IDLE;
          armed_d = 1'b0;
          if (is_zero) begin
            if (cfg.gcen) begin
              hit    = 1'b1;
              hit_gc = 1'b1;
            end
          end else if (cfg.ten) begin
            if (is_hdr && !byte_data[0]) begin
              st_d  = SEQ_LOW;
              hdr_d = byte_data[2:1];
            end else if (is_hdr && byte_data[0] && armed_q && (byte_data[2:1] == hi_q)) begin
              hit     = 1'b1;
              hit_rd  = 1'b1;
              armed_d = 1'b1;
            end
          end else if (cmp_ok) begin
            hit    = 1'b1;
            hit_rd = byte_data[0];
          end
        end
        SEQ_LOW: begin
          st_d = SEQ_IDLE;
          if (cmp_ok) begin
            hit     = 1'b1;
            armed_d = 1'b1;
            hi_d    = hdr_q;
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      armed_q <= 1'b0;
      hi_q    <= '0;
      hdr_q   <= '0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      hi_q    <= hi_d;
      hdr_q   <= hdr_d;
    end
  end
endmodule

// File: rtl/i2c_client_addr_match.sv
module i2c_client_addr_match
  import i2c_client_addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [1:0]        mode_sel,
  input  logic              start_in,
  input  logic              stop_in,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              flag_clr,
  output logic              match_flag,
  output logic              dir_rd,
  output logic              gcall_seen
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  cfg_t              cfg;
  logic [ADDR_W-1:0] cmp_addr;
  logic              cmp_ok, hit, hit_rd, hit_gc;
  logic              flag_d, flag_q, dir_d, dir_q, gc_d, gc_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_client_addr_cfg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg(cfg)
  );

  i2c_client_addr_cmp u_cmp (
    .cfg(cfg), .mode_sel(mode_sel), .rx_addr(cmp_addr), .cmp_ok(cmp_ok)
  );

  i2c_client_addr_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .cfg(cfg), .start_in(start_in), .stop_in(stop_in),
    .byte_vld(byte_vld), .byte_data(byte_data), .cmp_ok(cmp_ok), .cmp_addr(cmp_addr),
    .hit(hit), .hit_rd(hit_rd), .hit_gc(hit_gc)
  );

  always_comb begin
    flag_d = flag_q;
    dir_d  = dir_q;
    gc_d   = gc_q;
    if (hit) begin
      flag_d = 1'b1;
      dir_d  = hit_rd;
      gc_d   = hit_gc;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flag_q <= 1'b0;
      dir_q  <= 1'b0;
      gc_q   <= 1'b0;
    end else begin
      if (hit || flag_clr) flag_q <= flag_d;
      if (hit) begin
        dir_q <= dir_d;
        gc_q  <= gc_d;
      end
    end
  end

  assign match_flag = flag_q;
  assign dir_rd     = dir_q;
  assign gcall_seen = gc_q;
endmodule

// File: rtl/i2c_client_addr_match_chk.sv
module i2c_client_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic [7:0] byte_data,
  input logic       flag_clr,
  input logic       match_flag,
  input logic       dir_rd,
  input logic       gcall_seen
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag && !flag_clr |=> match_flag); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !byte_vld |=> !match_flag); // R9
  AST_HOLD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(dir_rd) && $stable(gcall_seen)); // R10
  AST_RISE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(byte_vld)); // R9
  AST_GCALL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_seen |-> !dir_rd); // R8
  AST_GCALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_seen) |-> $past(byte_data) == 8'h00); // R8
endmodule

bind i2c_client_addr_match i2c_client_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
  .flag_clr(flag_clr), .match_flag(match_flag), .dir_rd(dir_rd), .gcall_seen(gcall_seen)
);

// File: tb/i2c_client_addr_match_test.sv
module i2c_client_addr_match_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  mode_sel = '0;
  logic        start_in = 1'b0, stop_in = 1'b0, byte_vld = 1'b0, flag_clr = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        match_flag, dir_rd, gcall_seen;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  i2c_client_addr_match uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .mode_sel(mode_sel),
    .start_in(start_in), .stop_in(stop_in), .byte_vld(byte_vld), .byte_data(byte_data),
    .flag_clr(flag_clr), .match_flag(match_flag), .dir_rd(dir_rd), .gcall_seen(gcall_seen)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit [9:0] prim, bit [9:0] sec, bit ten, bit gcen);
    logic [31:0] w = '0;
    w[10:1] = prim; w[26:17] = sec; w[15] = ten; w[0] = gcen;
    return w;
  endfunction

  // expected 7-bit match from the requirements
  function automatic bit exp7(bit [7:0] b, bit [9:0] p, bit [9:0] s, bit [1:0] m, bit gcen);
    bit [6:0] a = b[7:1];
    if (b == 8'h00) return gcen;
    case (m)
      2'd1:    return (a == p[6:0]) || (a == s[6:0]);
      2'd2:    return (a >= s[6:0]) && (a <= p[6:0]);
      default: return ((a ^ p[6:0]) & ~s[6:0]) == 7'd0;
    endcase
  endfunction

  task automatic cfg_write(logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic pulse_start();
    @(negedge clk); start_in = 1'b1; @(negedge clk); start_in = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_in = 1'b1; @(negedge clk); stop_in = 1'b0;
  endtask
  task automatic send(logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_data = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask
  task automatic clr();
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask
  task automatic xfer(logic [7:0] b);
    clr(); pulse_start(); send(b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [9:0] p, s;
    bit [1:0] m;
    bit [7:0] b;
    bit g, e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 flag", match_flag, 0); chk("R1 dir", dir_rd, 0); chk("R1 gc", gcall_seen, 0);
    send(8'h00); chk("R1 zero cfg, no gcall", match_flag, 0);

    // R2 plain 7-bit, read and write
    mode_sel = 2'd0;
    cfg_write(mk_cfg(10'h05A, 10'h000, 1'b0, 1'b0));
    xfer({7'h5A, 1'b1}); chk("R2 match", match_flag, 1); chk("R2 dir read", dir_rd, 1);
    xfer({7'h5A, 1'b0}); chk("R2 dir write", dir_rd, 0);
    xfer({7'h5B, 1'b0}); chk("R2 mismatch", match_flag, 0);
    // R11 bytes without start ignored
    clr(); send({7'h5A, 1'b1}); chk("R11 no start", match_flag, 0);
    chk("R10 dir kept", dir_rd, 0);
    // R9 sticky over a later mismatch, then clear
    xfer({7'h5A, 1'b1}); pulse_start(); send(8'h02);
    chk("R9 sticky", match_flag, 1); chk("R10 dir unchanged", dir_rd, 1);
    clr(); chk("R9 clear", match_flag, 0);
    // R9 set wins over clear
    pulse_start();
    @(negedge clk); byte_vld = 1'b1; byte_data = {7'h5A, 1'b0}; flag_clr = 1'b1;
    @(negedge clk); byte_vld = 1'b0; flag_clr = 1'b0;
    chk("R9 set beats clear", match_flag, 1);

    // R5 mask (mode 0 and 3)
    cfg_write(mk_cfg(10'h040, 10'h00F, 1'b0, 1'b0));
    xfer({7'h4B, 1'b0}); chk("R5 masked bits", match_flag, 1);
    xfer({7'h5B, 1'b0}); chk("R5 unmasked bit", match_flag, 0);
    mode_sel = 2'd3;
    xfer({7'h47, 1'b0}); chk("R5 mode3 as mask", match_flag, 1);

    // R6 dual
    mode_sel = 2'd1;
    cfg_write(mk_cfg(10'h011, 10'h022, 1'b0, 1'b0));
    xfer({7'h22, 1'b1}); chk("R6 second addr", match_flag, 1);
    xfer({7'h11, 1'b0}); chk("R6 primary", match_flag, 1);
    xfer({7'h33, 1'b0}); chk("R6 neither", match_flag, 0);

    // R7 range boundaries
    mode_sel = 2'd2;
    cfg_write(mk_cfg(10'h020, 10'h010, 1'b0, 1'b0));
    xfer({7'h0F, 1'b0}); chk("R7 below", match_flag, 0);
    xfer({7'h10, 1'b0}); chk("R7 low edge", match_flag, 1);
    xfer({7'h20, 1'b0}); chk("R7 high edge", match_flag, 1);
    xfer({7'h21, 1'b0}); chk("R7 above", match_flag, 0);

    // R8 general call off/on
    mode_sel = 2'd0;
    cfg_write(mk_cfg(10'h000, 10'h000, 1'b0, 1'b0));
    xfer(8'h00); chk("R8 gc disabled", match_flag, 0);
    cfg_write(mk_cfg(10'h033, 10'h000, 1'b0, 1'b1));
    xfer({7'h33, 1'b1}); chk("R10 gc low on normal", gcall_seen, 0);
    xfer(8'h00); chk("R8 gc enabled", match_flag, 1);
    chk("R8 gc flag", gcall_seen, 1); chk("R8 gc dir write", dir_rd, 0);

    // R3 10-bit write sequence, address 0x2A5
    cfg_write(mk_cfg(10'h2A5, 10'h000, 1'b1, 1'b0));
    clr(); pulse_start(); send(8'hF4);
    chk("R3 no match after header", match_flag, 0);
    send(8'hA5); chk("R3 match after low byte", match_flag, 1); chk("R3 dir write", dir_rd, 0);
    // R4 repeated start with read header
    clr(); pulse_start(); send(8'hF5);
    chk("R4 read header match", match_flag, 1); chk("R4 dir read", dir_rd, 1);
    // R11 stop cancels read permission
    pulse_stop(); xfer(8'hF5); chk("R11 after stop", match_flag, 0);
    // R3 read header never starts a sequence
    xfer(8'hF5); send(8'hA5); chk("R3 read header no seq", match_flag, 0);
    // R3 wrong high bits / low byte
    xfer(8'hF2); send(8'hA5); chk("R3 high bits differ", match_flag, 0);
    xfer(8'hF4); send(8'hA4); chk("R3 low byte differs", match_flag, 0);
    // R11 non-matching start cancels read permission
    xfer(8'hF4); send(8'hA5); chk("R3 rematch", match_flag, 1);
    xfer(8'h12); xfer(8'hF5); chk("R11 after other addr", match_flag, 0);
    // R4 header high bits must agree
    xfer(8'hF4); send(8'hA5); xfer(8'hF3); chk("R4 high bits differ", match_flag, 0);

    // random 7-bit transfers (R2, R5, R6, R7, R8)
    for (int i = 0; i < 300; i++) begin
      m = 2'($urandom); p = 10'($urandom); s = 10'($urandom); g = 1'($urandom);
      if (m == 2'd2 && s[6:0] > p[6:0]) begin s[6:0] = p[6:0]; p[6:0] = 7'($urandom) | s[6:0]; end
      case ($urandom % 4)
        0: b = {p[6:0], 1'($urandom)};
        1: b = {s[6:0], 1'($urandom)};
        2: b = 8'h00;
        default: b = 8'($urandom);
      endcase
      mode_sel = m;
      cfg_write(mk_cfg(p, s, 1'b0, g));
      xfer(b);
      e = exp7(b, p, s, m, g);
      chk("R2 R5 R6 R7 R8 random", match_flag, e);
      if (e) begin
        chk("R10 random dir", dir_rd, b[0]);
        chk("R10 random gc", gcall_seen, b == 8'h00);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule